// File: doc/BRIEF.md
# Multi-Core Wait/Wake Event Unit

This unit is shared by a configurable number of processor cores and provides a low-power wait and wake handshake between them. Each core reports two kinds of one-cycle pulse: a "wait" hint, issued when it wants to idle until another core signals it, and a "wake" hint, issued to signal every core in the complex. Each core also presents a level that is high while it has an interrupt pending. In return each core receives a sleep output, which holds it idle while high, and a view of its own pending-event bit.

Every wake hint is broadcast to all cores, including the one that sent it, and it is recorded in a sticky per-core pending bit. A wait hint that finds its pending bit set, or that coincides with a wake hint or a pending interrupt, falls through at once and leaves the bit clear. A wait hint that finds nothing pending puts the core to sleep on the next cycle. A sleeping core is released one cycle after any wake hint or one cycle after its interrupt level rises. Several wake hints that arrive before a wait collapse into a single event. Wake hints are the only input that ever sets a pending bit. Wait hints are the only input that ever clears one, except that a wake hint seen by a sleeping core is used up by that wake-up.

Top module: `wake_event_unit`

## Requirements
- R1: Out of reset every bit of `sleep_o` and `event_pend_o` is 0.
- R2: A wake pulse from any core sets `event_pend_o` on the next cycle for every core that is awake and not issuing a wait pulse, the sending core included.
- R3: Any number of wake pulses before a wait collapse into one pending event. The first wait falls through. A second wait with no new wake pulse puts the core to sleep.
- R4: A wait pulse from an awake core whose pending bit is 1 keeps `sleep_o` at 0 and clears `event_pend_o` on the next cycle.
- R5: A wait pulse from an awake core with its pending bit at 0, with no wake pulse from any core and its interrupt level at 0 in the same cycle, drives that core's `sleep_o` to 1 on the next cycle.
- R6: A sleeping core returns `sleep_o` to 0 one cycle after a wake pulse from any core. Its pending bit stays 0.
- R7: A sleeping core whose interrupt level is 1 returns `sleep_o` to 0 on the next cycle. Its pending bit is left as it was (0).
- R8: A wait pulse and a wake pulse in the same cycle, for the same core, count as an event already received. The core does not sleep and its pending bit ends at 0.
- R9: A wait pulse from an awake core whose interrupt level is 1 falls through. The core does not sleep and its pending bit ends at 0.
- R10: A wait pulse that arrives while the same core is asleep has no effect. `sleep_o` stays 1 and `event_pend_o` stays 0 unless a wake condition is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_pulse_i | input | NUM_CORES | One-cycle wait hint, one bit per core |
| wake_pulse_i | input | NUM_CORES | One-cycle wake hint, one bit per core |
| irq_pend_i | input | NUM_CORES | Interrupt-pending level, one bit per core |
| sleep_o | output | NUM_CORES | High while the core is held idle |
| event_pend_o | output | NUM_CORES | Sticky pending-event bit of each core |

## Verification
A pending bit stuck or dropped shows up at the next wait from that core. That wait either sleeps when it should fall through, or falls through when it should sleep, and `sleep_o` disagrees one cycle after the pulse. A missing broadcast leg leaves one core's `event_pend_o` low on the cycle after a peer's wake pulse. A wrong sleep state is visible as soon as the next wake pulse or interrupt fails to clear `sleep_o` one cycle later. The bench compares both output vectors on every cycle against a model that it holds itself, so any divergence is reported within one cycle.

// File: rtl/wake_event_pkg.sv
package wake_event_pkg;

  typedef enum logic [1:0] {
    SLOT_HOLD    = 2'd0,
    SLOT_RECORD  = 2'd1,
    SLOT_PASS    = 2'd2,
    SLOT_DOZE    = 2'd3
  } slot_action_e;

  typedef struct packed {
    logic sleep;
    logic pend;
  } slot_state_t;

  // A wait hint falls through when an event is already stored, when one
  // arrives in the same cycle, or when the core has an interrupt pending.
  function automatic logic wait_falls_through(input logic pend,
                                              input logic any_wake,
                                              input logic irq);
    return pend | any_wake | irq;
  endfunction

  // A sleeping core is released by any broadcast wake or its own interrupt.
  function automatic logic wake_release(input logic any_wake, input logic irq);
    return any_wake | irq;
  endfunction

  // Classify what the slot does this cycle, for the awake case.
  function automatic slot_action_e awake_action(input logic wait_hit,
                                                input logic pend,
                                                input logic any_wake,
                                                input logic irq);
    if (wait_hit) begin
      if (wait_falls_through(pend, any_wake, irq)) return SLOT_PASS;
      return SLOT_DOZE;
    end
    if (any_wake) return SLOT_RECORD;
    return SLOT_HOLD;
  endfunction

endpackage

// File: rtl/wake_broadcast.sv
module wake_broadcast #(
  parameter int NUM_CORES = 4
) (
  input  logic [NUM_CORES-1:0] wake_pulse_i,
  output logic                 any_wake_o,
  output logic [NUM_CORES-1:0] wake_fanout_o
);

  localparam int CHAIN_LEN = NUM_CORES + 1;

  logic [CHAIN_LEN-1:0] or_chain;

  assign or_chain[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < NUM_CORES; g++) begin : g_or
      assign or_chain[g+1] = or_chain[g] | wake_pulse_i[g];
    end
  endgenerate

  assign any_wake_o = or_chain[CHAIN_LEN-1];

  // The event reaches every core, the sender included.
  generate
    for (g = 0; g < NUM_CORES; g++) begin : g_fan
      assign wake_fanout_o[g] = any_wake_o;
    end
  endgenerate

  always_comb begin
    assert (any_wake_o == (wake_pulse_i != '0))
      else $error("assert_broadcast_or_R2: reduction mismatch");
  end

endmodule

// File: rtl/wait_slot.sv
module wait_slot
  import wake_event_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wait_hit_i,
  input  logic wake_seen_i,
  input  logic irq_i,
  output logic sleep_o,
  output logic pend_o
);

  slot_state_t  cur_q, nxt;
  slot_action_e act;
  logic         release_now;

  assign release_now = wake_release(wake_seen_i, irq_i);
  assign act         = awake_action(wait_hit_i, cur_q.pend, wake_seen_i, irq_i);

  always_comb begin
    nxt = cur_q;
    if (cur_q.sleep) begin
      // Wait hints from a sleeping core are ignored; a broadcast wake is
      // consumed by the wake-up, an interrupt leaves the bit alone.
      if (release_now) nxt.sleep = 1'b0;
    end else begin
      unique case (act)
        SLOT_RECORD: nxt.pend = 1'b1;
        SLOT_PASS: begin
          nxt.pend  = 1'b0;
          nxt.sleep = 1'b0;
        end
        SLOT_DOZE: begin
          nxt.pend  = 1'b0;
          nxt.sleep = 1'b1;
        end
        default: nxt = cur_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  assign sleep_o = cur_q.sleep;
  assign pend_o  = cur_q.pend;

  assert_doze_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o && wait_hit_i && !pend_o && !wake_seen_i && !irq_i) |=> sleep_o);

  assert_fall_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o && wait_hit_i && (pend_o || wake_seen_i || irq_i)) |=> (!sleep_o && !pend_o));

  assert_peer_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && wake_seen_i) |=> (!sleep_o && !pend_o));

  assert_irq_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && irq_i) |=> !sleep_o);

  assert_record_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o && !wait_hit_i && wake_seen_i) |=> pend_o);

  assert_asleep_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o && !wake_seen_i && !irq_i) |=> (sleep_o && !pend_o));

  assert_sleep_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_o) |-> $past(wait_hit_i));

endmodule

// File: rtl/wake_event_unit.sv
module wake_event_unit #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] wait_pulse_i,
  input  logic [NUM_CORES-1:0] wake_pulse_i,
  input  logic [NUM_CORES-1:0] irq_pend_i,
  output logic [NUM_CORES-1:0] sleep_o,
  output logic [NUM_CORES-1:0] event_pend_o
);

  logic                 any_wake;
  logic [NUM_CORES-1:0] wake_fanout;

  wake_broadcast #(.NUM_CORES(NUM_CORES)) u_bcast (
    .wake_pulse_i (wake_pulse_i),
    .any_wake_o   (any_wake),
    .wake_fanout_o(wake_fanout)
  );

  genvar c;
  generate
    for (c = 0; c < NUM_CORES; c++) begin : g_slot
      wait_slot u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .wait_hit_i (wait_pulse_i[c]),
        .wake_seen_i(wake_fanout[c]),
        .irq_i      (irq_pend_i[c]),
        .sleep_o    (sleep_o[c]),
        .pend_o     (event_pend_o[c])
      );
    end
  endgenerate

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (sleep_o == '0 && event_pend_o == '0));

  assert_sender_reflect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wake && (sleep_o == '0) && (wait_pulse_i == '0)) |=> (event_pend_o == '1));

endmodule

// File: tb/wake_event_unit_test.sv
module wake_event_unit_test;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] wt = '0, wk = '0, iq = '0;
  logic [N-1:0] sleep_o, event_pend_o;
  logic [N-1:0] m_sleep = '0, m_pend = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  wake_event_unit #(.NUM_CORES(N)) uut (
    .clk(clk), .rst_n(rst_n),
    .wait_pulse_i(wt), .wake_pulse_i(wk), .irq_pend_i(iq),
    .sleep_o(sleep_o), .event_pend_o(event_pend_o)
  );

  // Next sleep state of one core, written from the requirements.
  function automatic logic exp_sleep(logic s, logic p, logic w, logic anyk, logic q);
    if (s) return !(anyk || q);
    if (w) return !(p || anyk || q);
    return 1'b0;
  endfunction

  function automatic logic exp_pend(logic s, logic p, logic w, logic anyk);
    if (s) return p;
    if (w) return 1'b0;
    return p | anyk;
  endfunction

  task automatic check(input logic ok, input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [N-1:0] w, input logic [N-1:0] k,
                     input logic [N-1:0] q, input string req);
    logic [N-1:0] ns, np;
    wt = w; wk = k; iq = q;
    for (int i = 0; i < N; i++) begin
      ns[i] = exp_sleep(m_sleep[i], m_pend[i], w[i], |k, q[i]);
      np[i] = exp_pend(m_sleep[i], m_pend[i], w[i], |k);
    end
    @(posedge clk); #1;
    m_sleep = ns; m_pend = np;
    wt = '0; wk = '0;
    check(sleep_o == m_sleep, req, sleep_o, m_sleep, "sleep");
    check(event_pend_o == m_pend, req, event_pend_o, m_pend, "pend");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] rw, rk, rq;
    repeat (3) @(posedge clk);
    #1;
    check(sleep_o == '0 && event_pend_o == '0, "R1", {sleep_o}, '0, "reset");
    rst_n = 1'b1;
    // R5: wait with nothing pending -> sleep next cycle.
    cyc(4'b0001, '0, '0, "R5");
    check(sleep_o[0] == 1'b1, "R5", sleep_o, 4'b0001, "core0 dozes");
    // R10: wait while asleep is ignored.
    cyc(4'b0001, '0, '0, "R10");
    // R6: peer core 2 wakes core 0; everyone else records.
    cyc('0, 4'b0100, '0, "R6");
    check(sleep_o == '0 && event_pend_o == 4'b1110, "R6", event_pend_o, 4'b1110, "pend after peer wake");
    // R2: sender reflection, core 3 alone.
    cyc('0, 4'b1000, '0, "R2");
    check(event_pend_o == 4'b1111, "R2", event_pend_o, 4'b1111, "all pending");
    // R3: more wakes collapse, then wait passes, second wait sleeps.
    cyc('0, 4'b0011, '0, "R3");
    cyc(4'b0010, '0, '0, "R3");
    check(sleep_o[1] == 1'b0 && event_pend_o[1] == 1'b0, "R4", sleep_o, '0, "fall through");
    cyc(4'b0010, '0, '0, "R3");
    check(sleep_o[1] == 1'b1, "R3", sleep_o, 4'b0010, "second wait sleeps");
    // R7: interrupt releases core 1.
    cyc('0, '0, 4'b0010, "R7");
    check(sleep_o[1] == 1'b0, "R7", sleep_o, '0, "irq release");
    iq = '0;
    // Consume remaining events.
    cyc(4'b1111, '0, '0, "R4");
    cyc(4'b1111, '0, '0, "R5");
    cyc('0, '0, 4'b1111, "R7");
    iq = '0;
    // R8: wait and wake in same cycle.
    cyc(4'b0100, 4'b0100, '0, "R8");
    check(sleep_o[2] == 1'b0 && event_pend_o[2] == 1'b0, "R8", event_pend_o, 4'b1011, "simultaneous");
    cyc(4'b1111, '0, '0, "R4");
    // R9: wait with interrupt level high.
    cyc(4'b0001, '0, 4'b0001, "R9");
    check(sleep_o[0] == 1'b0 && event_pend_o[0] == 1'b0, "R9", sleep_o, '0, "irq pass");
    iq = '0;
    // Random phase; awake cores only issue hints.
    void'($urandom(32'd1234));
    for (int t = 0; t < 3000; t++) begin
      rw = $urandom & ~m_sleep;
      rk = ($urandom % 5 == 0) ? ($urandom & ~m_sleep) : '0;
      rq = ($urandom % 7 == 0) ? N'($urandom) : '0;
      if (t % 50 == 0) rw = rw | m_sleep;   // R10 pulses while asleep
      cyc(rw, rk, rq, "R2-mix R4 R5 R6 R7 R8 R9 R10");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule